// File: doc/BRIEF.md
# Dual-Pool Erase-Count Wear Leveler

This block tracks how many times each erase block of a small flash array has been erased and uses those counts to steer wear. Every so many erase reports it recomputes the average erase count by walking the counters one block per cycle. When that walk ends, it splits the blocks into two groups: blocks at or below the average are cold, and blocks above it are hot. Requests for a fresh block are served from the free cold blocks first. A free hot block is handed out only when no free cold block is left.

The block also watches the distance between the most worn and the least worn block. When that distance grows past a set limit, it asks the surrounding controller to move data from the most worn block into the least worn one. The controller reports each erase, marks blocks free again after reclaiming them, and asks for a block whenever it needs one to write. The data move, the flash commands and the saving of the counters belong to the controller.

Top module: `wear_pool_leveler`

## Requirements
- R1: After reset every block has a count of zero, every block is free and belongs to the cold group, pool_empty is low and swap_req is low.
- R2: Each erase report adds one to the named block's counter. Once a counter reaches 2^CNT_W-1 it stays there and does not wrap to zero.
- R3: Each RECALC_EVERY-th erase report starts a scan that sums all the counters, one block per clock. At the end of the scan the average is the sum divided by NBLK, rounded down. The hot and cold groups are rebuilt only at that point: a block is hot when its count is strictly greater than the average, so a block whose count equals the average is cold.
- R4: While alloc_req is high and at least one block is free, alloc_gnt is high in the same cycle. alloc_idx then names the lowest-numbered free cold block, and on the next clock edge that block leaves the free set.
- R5: When every free block is hot, the grant names the free block with the smallest count. Among equal counts, the lowest index wins.
- R6: When no block is free, pool_empty is high and alloc_gnt stays low even while alloc_req is high.
- R7: A free mark (free_vld with free_idx) returns that block to the free set, so a later request can grant it.
- R8: swap_req is high exactly when the largest count minus the smallest count exceeds GAP_MAX. swap_hot names the block with the largest count and swap_cold the block with the smallest count; in both cases the lowest index wins a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_vld | input | 1 | An erase of block erase_idx has been performed |
| erase_idx | input | IDX_W | Index of the erased block |
| free_vld | input | 1 | Mark block free_idx as free |
| free_idx | input | IDX_W | Index of the block being freed |
| alloc_req | input | 1 | Request for a free block |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_idx | output | IDX_W | Granted block index |
| pool_empty | output | 1 | No block is free |
| swap_req | output | 1 | Wear spread exceeds GAP_MAX |
| swap_hot | output | IDX_W | Most-erased block, source of the move |
| swap_cold | output | IDX_W | Least-erased block, target of the move |

## Verification
A wrong counter shows up on swap_req, swap_hot and swap_cold in the cycle right after the erase, because those outputs are built directly from the counters. A saturating counter that wraps instead lets a less worn block win the largest-count slot. A wrong average, or a hot/cold bit updated at the wrong time, only shows up in the order of grants. So the bench lets each scan finish and then drains the free set, reading the full grant order, including the block whose count equals the average and the fallback to hot blocks ordered by count. A corrupted free set shows at once as a wrong alloc_idx or a wrong pool_empty.

// File: rtl/wear_pool_leveler.sv
`timescale 1ns/1ps
module wear_pool_leveler #(
  parameter int NBLK         = 32,
  parameter int CNT_W        = 16,
  parameter int RECALC_EVERY = 16,
  parameter int GAP_MAX      = 64,
  localparam int IDX_W       = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_vld,
  input  logic [IDX_W-1:0] erase_idx,
  input  logic             free_vld,
  input  logic [IDX_W-1:0] free_idx,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             pool_empty,
  output logic             swap_req,
  output logic [IDX_W-1:0] swap_hot,
  output logic [IDX_W-1:0] swap_cold
);
  localparam int SUM_W = CNT_W + IDX_W;
  localparam int EV_W  = $clog2(RECALC_EVERY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(NBLK - 1);
  localparam logic [SUM_W-1:0] DIVISOR  = SUM_W'(NBLK);
  localparam logic [EV_W-1:0]  EV_LAST  = EV_W'(RECALC_EVERY - 1);
  localparam logic [CNT_W:0]   GAP_LIM  = (CNT_W+1)'(GAP_MAX);

  logic [CNT_W-1:0] cnt_q [NBLK];
  logic [NBLK-1:0]  free_q, hot_q, hot_next, set_mask, clr_mask;
  logic [CNT_W-1:0] mean_q, mean_next;
  logic [SUM_W-1:0] acc_q, acc_next;
  logic [IDX_W-1:0] pos_q;
  logic [EV_W-1:0]  ev_q;
  logic             busy_q, pend_q, trig, start;

  // erase counters, saturating
  always_ff @(posedge clk) begin
    for (int i = 0; i < NBLK; i++) begin
      if (!rst_n) cnt_q[i] <= '0;
      else if (erase_vld && erase_idx == IDX_W'(i) && cnt_q[i] != CNT_MAX)
        cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  // recompute trigger
  assign trig  = erase_vld && (ev_q == EV_LAST);
  assign start = pend_q && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (erase_vld) ev_q <= trig ? '0 : ev_q + 1'b1;
      pend_q <= (pend_q && !start) || trig;
    end
  end

  // sequential mean scan
  assign acc_next  = acc_q + SUM_W'(cnt_q[pos_q]);
  assign mean_next = CNT_W'(acc_next / DIVISOR);

  always_comb begin
    for (int i = 0; i < NBLK; i++) hot_next[i] = cnt_q[i] > mean_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      acc_q  <= '0;
      mean_q <= '0;
      hot_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_next;
      if (pos_q == LAST) begin
        busy_q <= 1'b0;
        mean_q <= mean_next;
        hot_q  <= hot_next;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
      acc_q  <= '0;
    end
  end

  // allocation select
  logic             cold_found, hot_found;
  logic [IDX_W-1:0] cold_idx, hot_idx;
  logic [CNT_W-1:0] hot_best;

  always_comb begin
    cold_found = 1'b0;
    cold_idx   = '0;
    hot_found  = 1'b0;
    hot_idx    = '0;
    hot_best   = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (free_q[i] && !hot_q[i] && !cold_found) begin
        cold_found = 1'b1;
        cold_idx   = IDX_W'(i);
      end
      if (free_q[i] && hot_q[i] && (!hot_found || cnt_q[i] < hot_best)) begin
        hot_found = 1'b1;
        hot_idx   = IDX_W'(i);
        hot_best  = cnt_q[i];
      end
    end
  end

  assign pool_empty = ~|free_q;
  assign alloc_gnt  = alloc_req && !pool_empty;
  assign alloc_idx  = cold_found ? cold_idx : hot_idx;

  always_comb begin
    for (int i = 0; i < NBLK; i++) begin
      set_mask[i] = free_vld && free_idx == IDX_W'(i);
      clr_mask[i] = alloc_gnt && alloc_idx == IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q | set_mask) & ~clr_mask;
  end

  // wear spread
  logic [CNT_W-1:0] max_v, min_v;

  always_comb begin
    max_v     = cnt_q[0];
    min_v     = cnt_q[0];
    swap_hot  = '0;
    swap_cold = '0;
    for (int i = 1; i < NBLK; i++) begin
      if (cnt_q[i] > max_v) begin
        max_v    = cnt_q[i];
        swap_hot = IDX_W'(i);
      end
      if (cnt_q[i] < min_v) begin
        min_v     = cnt_q[i];
        swap_cold = IDX_W'(i);
      end
    end
  end

  assign swap_req = {1'b0, max_v - min_v} > GAP_LIM;

  // checks
  assert_cnt_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_vld && cnt_q[erase_idx] == CNT_MAX) |=> cnt_q[$past(erase_idx)] == CNT_MAX);

  assert_cnt_never_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_vld |=> cnt_q[$past(erase_idx)] >= $past(cnt_q[erase_idx]));

  assert_pools_frozen_outside_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(mean_q) && $stable(hot_q)));

  assert_granted_block_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> !free_q[$past(alloc_idx)]);

  assert_no_grant_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |-> !alloc_gnt);

  assert_swap_pair_ordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |-> cnt_q[swap_hot] > cnt_q[swap_cold]);
endmodule

// File: tb/wear_pool_leveler_tb.sv
`timescale 1ns/1ps
module wear_pool_leveler_tb_top;
  localparam int NBLK = 8;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase_vld = 1'b0, free_vld = 1'b0, alloc_req = 1'b0;
  logic [IW-1:0] erase_idx = '0, free_idx = '0;
  logic          alloc_gnt, pool_empty, swap_req;
  logic [IW-1:0] alloc_idx, swap_hot, swap_cold;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wear_pool_leveler #(.NBLK(NBLK), .CNT_W(4), .RECALC_EVERY(4), .GAP_MAX(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .erase_vld(erase_vld), .erase_idx(erase_idx),
    .free_vld(free_vld), .free_idx(free_idx),
    .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .pool_empty(pool_empty),
    .swap_req(swap_req), .swap_hot(swap_hot), .swap_cold(swap_cold));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_erase(input int idx, input int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      erase_vld = 1'b1;
      erase_idx = IW'(idx);
      @(posedge clk);
      #1 erase_vld = 1'b0;
    end
  endtask

  task automatic do_free(input int idx);
    @(negedge clk);
    free_vld = 1'b1;
    free_idx = IW'(idx);
    @(posedge clk);
    #1 free_vld = 1'b0;
  endtask

  task automatic expect_alloc(input string tag, input int exp_idx);
    @(negedge clk);
    alloc_req = 1'b1;
    #1;
    check({tag, " gnt"}, alloc_gnt, 1);
    check({tag, " idx"}, alloc_idx, exp_idx);
    @(posedge clk);
    #1 alloc_req = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    alloc_req = 1'b1;
    #1;
    check({tag, " empty"}, pool_empty, 1);
    check({tag, " gnt"}, alloc_gnt, 0);
    @(posedge clk);
    #1 alloc_req = 1'b0;
  endtask

  task automatic wait_scan();
    repeat (40) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pool_empty", pool_empty, 0);
    check("R1 swap_req", swap_req, 0);
    check("R1 gnt idle", alloc_gnt, 0);
  endtask

  task automatic t_drain_fresh();
    for (int b = 0; b < NBLK; b++) expect_alloc("R4 fresh order", b);
    expect_empty("R6 all taken");
  endtask

  task automatic t_free_mark();
    do_free(5);
    @(negedge clk);
    check("R7 not empty after free", pool_empty, 0);
    expect_alloc("R7 freed block", 5);
    for (int b = 0; b < NBLK; b++) do_free(b);
  endtask

  task automatic t_spread_and_classify();
    do_erase(0, 3);
    @(negedge clk);
    check("R8 spread 3 at limit", swap_req, 0);
    do_erase(0, 1);
    @(negedge clk);
    check("R8 spread 4 over limit", swap_req, 1);
    check("R8 hot", swap_hot, 0);
    check("R8 cold", swap_cold, 1);
    wait_scan();
    expect_alloc("R3 hot block skipped", 1);
    do_free(1);
  endtask

  task automatic t_fallback();
    do_erase(2, 7);
    do_erase(3, 1);
    wait_scan();
    expect_alloc("R4 cold first", 1);
    expect_alloc("R3 equal to mean is cold", 3);
    for (int b = 4; b < NBLK; b++) expect_alloc("R4 cold order", b);
    expect_alloc("R5 lowest hot count", 0);
    expect_alloc("R5 next hot", 2);
    expect_empty("R6 drained");
    @(negedge clk);
    check("R8 hot after mix", swap_hot, 2);
    check("R8 cold after mix", swap_cold, 1);
  endtask

  task automatic t_saturate();
    do_erase(5, 20);
    @(negedge clk);
    check("R2 saturated block is max", swap_hot, 5);
    check("R2 swap raised", swap_req, 1);
    do_erase(2, 8);
    @(negedge clk);
    check("R8 tie lowest index hot", swap_hot, 2);
    check("R8 cold stays", swap_cold, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_drain_fresh();
    t_free_mark();
    t_spread_and_classify();
    t_fallback();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule